// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable, cycle-accurate model of a synchronous static RAM. Its pipeline lets read and write cycles follow each other in any order with no idle slot between them. It registers every control, address and data input on the rising clock edge. Read data comes back two enabled cycles after its address. Write data for an address is taken in the same slot two enabled cycles later, so every clock slot on the data path can carry a word.

A load cycle (`adv` low) either starts a new read, starts a new write or deselects the part. Each continue cycle (`adv` high) moves a 2-bit burst counter one step and repeats the operation that the last load started. The counter steps through the low address bits in either wrapping-linear or XOR-interleaved order. A clock-enable input freezes the whole pipeline. A read that directly follows a write to the same word gets the fresh bytes, because the read path forwards from the pending write.

Top module: `nt_sram`

## Requirements
- R1: A read loaded on an enabled edge shows its word on `rdata` with `rd_valid` high after the second enabled edge that follows. No idle slot is needed between read and write cycles in either direction.
- R2: While `clk_en_n` is high, a rising edge ignores all synchronous inputs. The outputs, the pipeline and the memory keep their values, and latency counts only enabled edges.
- R3: The part is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load under any other combination is a deselect: nothing is written, and in its data slot `rd_valid` is 0 and `rdata` is all zeros.
- R4: With `adv` low the address on `addr` is loaded. With `adv` high the burst advances and the operation of the last load (read, write or deselect) continues. On such a cycle `we_n` and the three chip selects are ignored.
- R5: If `ilv`=0 when the burst is loaded, step k (k=0..3) uses low address bits (start+k) mod 4. The bits above bit 1 stay fixed.
- R6: If `ilv`=1 when the burst is loaded, step k uses low address bits start XOR k.
- R7: A write is loaded with `we_n`=0. Its data is taken from `wdata` on the second enabled edge after its address. Byte lane i (`wdata[8i+7:8i]`) is stored only when `bw_n[i]`=0 on the edge that captured its address.
- R8: A write whose `bw_n` bits are all 1 is aborted and leaves the memory unchanged.
- R9: A read that directly follows a write to the same address returns the newly written lanes, merged with the old contents of the other lanes.
- R10: After reset, `rd_valid` is 0, `rdata` is 0, and the burst state is a deselect, so an `adv`-high cycle right after reset yields no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline state |
| clk_en_n | input | 1 | High suspends the cycle |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv | input | 1 | Low: load address; high: advance burst |
| we_n | input | 1 | Low: load starts a write |
| ilv | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| bw_n | input | NB | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | NB*BW | Late write data |
| rdata | output | NB*BW | Read data, zero when not valid |
| rd_valid | output | 1 | Read data present in this slot |

## Verification
The bench interleaves reads and writes back to back. A design that inserted a turnaround bubble, or slipped one slot, would return data in the wrong row. A read placed one cycle behind a partial write to the same word exposes a missing forwarding path, because it would return the stale word. Bursts that start mid-block in both orders catch a counter that fails to wrap or mixes up XOR and add. A read burst with `we_n` low and the chip deselected catches a design that resamples controls during continuation. Suspended edges with a hostile write on the pins would show up as a corrupted word or a shifted latency. An aborted write and loads under each partial select combination would show up as clobbered memory.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  typedef enum logic [1:0] {
    OP_DS = 2'd0,
    OP_RD = 2'd1,
    OP_WR = 2'd2
  } op_e;

  // Low two address bits for burst step k from a start offset.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/nt_sram_ctrl.sv
module nt_sram_ctrl
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              sel,
  input  logic              we_n,
  input  logic              ilv,
  input  logic [NB-1:0]     bw_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op1,
  output logic [ADDR_W-1:0] addr1,
  output logic [NB-1:0]     be1
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic              ilv_q;
  op_e               op_q;

  logic [1:0]        step_nx;
  logic [ADDR_W-1:0] burst_addr;
  op_e               new_op;

  assign step_nx    = step_q + 2'd1;
  assign burst_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], step_nx, ilv_q)};
  assign new_op     = sel ? (we_n ? OP_RD : OP_WR) : OP_DS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      ilv_q  <= 1'b0;
      op_q   <= OP_DS;
      op1    <= OP_DS;
      addr1  <= '0;
      be1    <= '0;
    end else if (en) begin
      be1 <= ~bw_n;
      if (!adv) begin
        base_q <= addr;
        step_q <= 2'd0;
        ilv_q  <= ilv;
        op_q   <= new_op;
        op1    <= new_op;
        addr1  <= addr;
      end else begin
        step_q <= step_nx;
        op1    <= op_q;
        addr1  <= burst_addr;
      end
    end
  end

endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 8,
  localparam int DW    = NB * BW,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NB-1:0]     wr_be,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_snap
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] fwd;
  logic [NB-1:0] byp_be;

  assign byp_be = (wr_en && (wr_addr == rd_addr)) ? wr_be : '0;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign fwd[g*BW +: BW] = byp_be[g] ? wdata[g*BW +: BW] : mem[rd_addr][g*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (en && wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_snap <= '0;
    else if (en) rd_snap <= fwd;
  end

endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NB     = 4,
  parameter int BW     = 8,
  localparam int DW    = NB * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic              ilv,
  input  logic [NB-1:0]     bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rd_valid
);

  logic en, sel, rd_start, ds_start;
  assign en       = !clk_en_n;
  assign sel      = !ce1_n && ce2 && !ce3_n;
  assign rd_start = en && !adv && sel && we_n;
  assign ds_start = en && !adv && !sel;

  op_e               op1, op2;
  logic [ADDR_W-1:0] addr1, addr2;
  logic [NB-1:0]     be1, be2;
  logic [DW-1:0]     rd_snap;
  logic              wr_slot;

  nt_sram_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .adv(adv), .sel(sel), .we_n(we_n),
    .ilv(ilv), .bw_n(bw_n), .addr(addr), .op1(op1), .addr1(addr1), .be1(be1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op2   <= OP_DS;
      addr2 <= '0;
      be2   <= '0;
    end else if (en) begin
      op2   <= op1;
      addr2 <= addr1;
      be2   <= be1;
    end
  end

  assign wr_slot = (op2 == OP_WR);

  nt_sram_array #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .rst_n(rst_n), .en(en), .rd_addr(addr1), .wr_en(wr_slot),
    .wr_addr(addr2), .wr_be(be2), .wdata(wdata), .rd_snap(rd_snap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else if (en) begin
      rd_valid <= (op2 == OP_RD);
      rdata    <= (op2 == OP_RD) ? rd_snap : '0;
    end
  end

endmodule

// File: rtl/nt_sram_chk.sv
module nt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          clk_en_n,
  input logic          rd_start,
  input logic          ds_start,
  input logic          rd_valid,
  input logic [DW-1:0] rdata
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && clk_en_n) |=> ($stable(rdata) && $stable(rd_valid))); // R2

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(rd_start, 3) && $past(en, 2) && $past(en, 1)) |-> rd_valid); // R1

  AST_DESEL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(ds_start, 3) && $past(en, 2) && $past(en, 1)) |-> !rd_valid); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !rd_valid) |-> (rdata == '0)); // R3

endmodule

bind nt_sram nt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clk_en_n(clk_en_n),
  .rd_start(rd_start), .ds_start(ds_start), .rd_valid(rd_valid), .rdata(rdata)
);

// File: tb/tb_nt_sram.sv
`timescale 1ns/1ps
module tb_nt_sram;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam logic [2:0] ON  = 3'b010; // {ce1_n, ce2, ce3_n}
  localparam logic [2:0] OFF = 3'b110;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clk_en_n, ce1_n, ce2, ce3_n, adv, we_n, ilv;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rd_valid;

  nt_sram #(.ADDR_W(AW), .NB(NB), .BW(8)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adv(adv), .we_n(we_n), .ilv(ilv), .bw_n(bw_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic          adv;
    logic [2:0]    cs;
    logic          wn;
    logic [3:0]    bn;
    logic [AW-1:0] ad;
    logic [DW-1:0] wd;
    logic          ev;
    logic [DW-1:0] ed;
  } vec_t;

  // Output after row i belongs to the load made in row i-2.
  localparam vec_t TBL [16] = '{
    '{1'b0, ON,  1'b0, 4'h0, 6'h10, 32'h0,         1'b0, 32'h0},          // write 10
    '{1'b0, ON,  1'b0, 4'h0, 6'h11, 32'h0,         1'b0, 32'h0},          // write 11
    '{1'b0, ON,  1'b1, 4'hF, 6'h10, 32'hAAAA0001,  1'b0, 32'h0},          // read 10, data R7
    '{1'b0, ON,  1'b0, 4'h0, 6'h12, 32'hBBBB0002,  1'b0, 32'h0},          // write 12, R9 turn
    '{1'b0, ON,  1'b1, 4'hF, 6'h11, 32'h0,         1'b1, 32'hAAAA0001},   // R1
    '{1'b0, ON,  1'b1, 4'hF, 6'h12, 32'hCCCC0003,  1'b0, 32'h0},
    '{1'b0, ON,  1'b1, 4'hF, 6'h12, 32'h0,         1'b1, 32'hBBBB0002},
    '{1'b0, ON,  1'b0, 4'b0101, 6'h12, 32'h0,      1'b1, 32'hCCCC0003},   // partial write 12
    '{1'b0, ON,  1'b1, 4'hF, 6'h12, 32'h0,         1'b1, 32'hCCCC0003},   // read right behind it
    '{1'b0, OFF, 1'b1, 4'hF, 6'h00, 32'h11223344,  1'b0, 32'h0},
    '{1'b0, OFF, 1'b1, 4'hF, 6'h00, 32'h0,         1'b1, 32'h11CC3303},   // R9 merged bypass
    '{1'b0, ON,  1'b0, 4'hF, 6'h10, 32'h0,         1'b0, 32'h0},          // aborted write R8
    '{1'b0, ON,  1'b1, 4'hF, 6'h10, 32'h0,         1'b0, 32'h0},
    '{1'b0, OFF, 1'b1, 4'hF, 6'h00, 32'hDEADBEEF,  1'b0, 32'h0},
    '{1'b0, OFF, 1'b1, 4'hF, 6'h00, 32'h0,         1'b1, 32'hAAAA0001},   // R8 unchanged
    '{1'b0, OFF, 1'b1, 4'hF, 6'h00, 32'h0,         1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (rd_valid !== ev || rdata !== (ev ? ed : '0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%08h, expected valid=%0b data=%08h",
               tag, rd_valid, rdata, ev, ev ? ed : '0);
    end
  endtask

  task automatic step(input logic a, input logic [2:0] cs, input logic wn,
                      input logic [3:0] bn, input logic [AW-1:0] ad, input logic il,
                      input logic [DW-1:0] wd, input logic susp);
    adv = a; {ce1_n, ce2, ce3_n} = cs; we_n = wn; bw_n = bn; addr = ad;
    ilv = il; wdata = wd; clk_en_n = susp;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [DW-1:0] wd);
    step(1'b0, OFF, 1'b1, 4'hF, '0, 1'b0, wd, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; adv = 1'b0; {ce1_n, ce2, ce3_n} = OFF;
    we_n = 1'b1; ilv = 1'b0; bw_n = 4'hF; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset outputs", 1'b0, 32'h0);

    // R10: continue cycle right after reset stays a deselect
    step(1'b1, ON, 1'b0, 4'h0, 6'h05, 1'b0, 32'h0, 1'b0);
    idle(32'h0);
    chk("R10 adv after reset", 1'b0, 32'h0);
    idle(32'h0);

    for (int i = 0; i < 16; i++) begin
      step(TBL[i].adv, TBL[i].cs, TBL[i].wn, TBL[i].bn, TBL[i].ad, 1'b0, TBL[i].wd, 1'b0);
      chk($sformatf("R1/R7 table row %0d", i), TBL[i].ev, TBL[i].ed);
    end

    // R2: suspend holds outputs; hostile write on the pins ignored
    step(1'b0, ON, 1'b1, 4'hF, 6'h11, 1'b0, 32'h0, 1'b0);
    step(1'b0, ON, 1'b1, 4'hF, 6'h10, 1'b0, 32'h0, 1'b0);
    idle(32'h0);
    chk("R2 before suspend", 1'b1, 32'hBBBB0002);
    step(1'b0, ON, 1'b0, 4'h0, 6'h10, 1'b0, 32'hFFFFFFFF, 1'b1);
    chk("R2 held during suspend", 1'b1, 32'hBBBB0002);
    step(1'b1, ON, 1'b0, 4'h0, 6'h10, 1'b0, 32'hFFFFFFFF, 1'b1);
    chk("R2 held second suspend", 1'b1, 32'hBBBB0002);
    idle(32'h0);
    chk("R2 latency counts enabled edges", 1'b1, 32'hAAAA0001);
    idle(32'h0);
    chk("R2 after resume", 1'b0, 32'h0);
    step(1'b0, ON, 1'b1, 4'hF, 6'h10, 1'b0, 32'h0, 1'b0);
    idle(32'h0); idle(32'h0);
    chk("R2 memory untouched by suspended write", 1'b1, 32'hAAAA0001);

    // R3: partial selects are deselects
    step(1'b0, 3'b110, 1'b0, 4'h0, 6'h11, 1'b0, 32'h0, 1'b0);
    step(1'b0, 3'b000, 1'b0, 4'h0, 6'h11, 1'b0, 32'h0, 1'b0);
    step(1'b0, 3'b011, 1'b0, 4'h0, 6'h11, 1'b0, 32'h0, 1'b0);
    step(1'b0, 3'b000, 1'b1, 4'hF, 6'h11, 1'b0, 32'h0, 1'b0);
    idle(32'h0);
    chk("R3 deselect write slot", 1'b0, 32'h0);
    idle(32'h0);
    chk("R3 deselected read slot", 1'b0, 32'h0);
    step(1'b0, ON, 1'b1, 4'hF, 6'h11, 1'b0, 32'h0, 1'b0);
    idle(32'h0); idle(32'h0);
    chk("R3 no write while deselected", 1'b1, 32'hBBBB0002);

    // R5: linear write burst from 22 -> 22,23,20,21
    step(1'b0, ON, 1'b0, 4'h0, 6'h22, 1'b0, 32'h0, 1'b0);
    step(1'b1, ON, 1'b0, 4'h0, 6'h00, 1'b0, 32'h0, 1'b0);
    step(1'b1, ON, 1'b0, 4'h0, 6'h00, 1'b0, 32'h50000022, 1'b0);
    step(1'b1, ON, 1'b0, 4'h0, 6'h00, 1'b0, 32'h50000023, 1'b0);
    idle(32'h50000020);
    idle(32'h50000021);
    idle(32'h0);

    // R6 and R4: interleaved read burst from 21; we_n low and deselect ignored
    step(1'b0, ON, 1'b1, 4'hF, 6'h21, 1'b1, 32'h0, 1'b0);
    step(1'b1, OFF, 1'b0, 4'h0, 6'h00, 1'b0, 32'h0, 1'b0);
    step(1'b1, OFF, 1'b0, 4'h0, 6'h00, 1'b0, 32'h0, 1'b0);
    chk("R6 interleave step0", 1'b1, 32'h50000021);
    step(1'b1, OFF, 1'b0, 4'h0, 6'h00, 1'b0, 32'h0, 1'b0);
    chk("R6 interleave step1", 1'b1, 32'h50000020);
    idle(32'h0);
    chk("R4 continue keeps read", 1'b1, 32'h50000023);
    idle(32'h0);
    chk("R6 interleave step3", 1'b1, 32'h50000022);

    // R5: linear read burst from 23 wraps
    step(1'b0, ON, 1'b1, 4'hF, 6'h23, 1'b0, 32'h0, 1'b0);
    step(1'b1, ON, 1'b1, 4'hF, 6'h00, 1'b1, 32'h0, 1'b0);
    step(1'b1, ON, 1'b1, 4'hF, 6'h00, 1'b1, 32'h0, 1'b0);
    chk("R5 linear step0", 1'b1, 32'h50000023);
    step(1'b1, ON, 1'b1, 4'hF, 6'h00, 1'b1, 32'h0, 1'b0);
    chk("R5 linear wrap", 1'b1, 32'h50000020);
    idle(32'h0);
    chk("R5 linear step2", 1'b1, 32'h50000021);
    idle(32'h0);
    chk("R5 linear step3", 1'b1, 32'h50000022);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no finish, expected finish within 5000 cycles");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule